// File: doc/BRIEF.md
# ATA Drive Bring-Up Sequencer

This block takes an ATA device from an unconfigured state to one that is ready for data commands. A `start` pulse launches the sequence. The block first masks device interrupts through the auxiliary control register. It then selects the drive and, after a settle window, waits for the device to report ready. Next it issues a chain of configuration commands. Each command in the chain is taken or skipped according to the capability and mode inputs. Every register access leaves the block as a one-cycle write of an 8-bit value to a 4-bit task-file address. After each command the block waits a short hold window, then polls the status register until the device is ready or a timeout expires.

Each step ends in one of four ways: success, timeout, generic error or device fault. The outcome is reported as a code together with the step that produced it. On exit, successful or not, the block writes the auxiliary control register again to unmask interrupts. It then pulses `done` for one cycle. After a success `ready` stays high, and later `start` pulses complete at once without touching the device. After a failure `ready` stays low, so the next `start` runs the whole sequence again. The capability, mode and geometry inputs must stay stable while a sequence is running. Address map: 1 features, 2 sector count, 4 cylinder low, 5 cylinder high, 6 device/head, 7 command, 8 auxiliary control.

Top module: `ata_bringup_seq`

## Requirements
- R1: Out of reset, `done`, `ready`, `wr_en`, `err_code`, `err_step` and `err_reg` are all zero.
- R2: A sequence opens by writing 0x0A (interrupt mask plus 4-bit head flag) to address 8. It closes, on success or failure, by writing 0x08 to address 8. When `no_aux_ctl` is high, neither write occurs.
- R3: The block selects the drive by writing 0xA0 | (drive_sel << 4) to address 6. The next write comes exactly SETTLE_CYC+2 cycles later. The first ready wait accepts stat bit 7 (busy) clear and bit 6 (ready) set, and ignores the error bits.
- R4: The steps run in this order, each step code given in brackets: recalibrate [1], PIO mode [2], DMA mode [3], geometry [4], multiple count [5]. Steps 2 and 3 are skipped unless both `can_set_modes` and `modes_known` are high. Step 3 is also skipped when neither `udma_en` nor `dma_en` is high. Step 4 is skipped when `lba_mode` is high, and step 5 is skipped when `multi_cnt` is 1.
- R5: Each step writes its task-file registers in a fixed order:
  - recalibrate: addr 6 = dev, then addr 7 = 0x10.
  - mode steps: addr 1 = 0x03, then addr 2 = mode byte, then addr 6 = dev, then addr 7 = 0xEF.
  - geometry: addr 2 = spt, then addr 4 = cyl[7:0], then addr 5 = cyl[15:8], then addr 6 = dev | (heads-1)[3:0], then addr 7 = 0x91.
  - multiple count: addr 2 = multi_cnt, then addr 6 = dev, then addr 7 = 0xC6.
- R6: The PIO mode byte is 0x08 | pio_mode. The DMA mode byte is 0x40 | udma_mode when `udma_en` is high, which takes priority. Otherwise it is 0x20 | dma_mode.
- R7: After each command write the block holds for HOLD_CYC cycles before sampling status. When the device is ready at once, the next write follows the command write by HOLD_CYC+2 cycles. If the device is not ready within TIMEOUT_CYC polls, the sequence fails with `err_code` 1 and `err_step` set to the current step code (0 for the first wait).
- R8: After a command completes, a set device-fault bit (stat bit 5) fails the step with `err_code` 3. This takes priority over the error bit. Otherwise a set error bit (stat bit 0) fails the step with `err_code` 2 and latches `err_in` into `err_reg`.
- R9: After a failure `ready` stays low. The next `start` repeats the full sequence from the first write.
- R10: `done` is high for exactly one cycle per sequence. On success `ready` rises in the same cycle as `done`. A `start` while `ready` is high yields a `done` pulse with `err_code` 0 and no register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse |
| drive_sel | input | 1 | Drive index |
| no_aux_ctl | input | 1 | Auxiliary control register absent |
| can_set_modes | input | 1 | Controller supports mode changes |
| modes_known | input | 1 | Drive reported its transfer modes |
| udma_en | input | 1 | Ultra DMA enabled |
| dma_en | input | 1 | Multiword DMA enabled |
| lba_mode | input | 1 | Logical block addressing in use |
| pio_mode | input | 3 | PIO mode number |
| dma_mode | input | 3 | Multiword DMA mode number |
| udma_mode | input | 3 | Ultra DMA mode number |
| geo_cyl | input | 16 | Cylinder count |
| geo_heads | input | 5 | Head count (1..16) |
| geo_spt | input | 8 | Sectors per track |
| multi_cnt | input | 8 | Sectors per multiple transfer |
| stat_in | input | 8 | Device status register |
| err_in | input | 8 | Device error register |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 4 | Register address |
| wr_data | output | 8 | Register write data |
| done | output | 1 | Sequence finished (one cycle) |
| ready | output | 1 | Drive configured |
| err_code | output | 2 | 0 ok, 1 timeout, 2 error, 3 device fault |
| err_step | output | 3 | Step code of the failure |
| err_reg | output | 8 | Captured error register |

## Verification
If the step register held a wrong value, it would show up within a few cycles. A wrong step would insert, omit or misplace a command byte in the write stream. The bench compares that stream entry by entry against a list built from the capability inputs. A corrupted outcome code or a `ready` flag that is not cleared shows at the single `done` cycle, because `err_code`, `err_step` and `ready` are sampled there. A wrong count in the settle or hold counters moves the first write that follows a select or a command. The bench measures that gap in cycles.

// File: rtl/ata_bringup_seq.sv
module ata_bringup_seq #(
  parameter logic [31:0] SETTLE_CYC  = 32'd2500,
  parameter logic [31:0] HOLD_CYC    = 32'd100,
  parameter logic [31:0] TIMEOUT_CYC = 32'd2500000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        drive_sel,
  input  logic        no_aux_ctl,
  input  logic        can_set_modes,
  input  logic        modes_known,
  input  logic        udma_en,
  input  logic        dma_en,
  input  logic        lba_mode,
  input  logic [2:0]  pio_mode,
  input  logic [2:0]  dma_mode,
  input  logic [2:0]  udma_mode,
  input  logic [15:0] geo_cyl,
  input  logic [4:0]  geo_heads,
  input  logic [7:0]  geo_spt,
  input  logic [7:0]  multi_cnt,
  input  logic [7:0]  stat_in,
  input  logic [7:0]  err_in,
  output logic        wr_en,
  output logic [3:0]  wr_addr,
  output logic [7:0]  wr_data,
  output logic        done,
  output logic        ready,
  output logic [1:0]  err_code,
  output logic [2:0]  err_step,
  output logic [7:0]  err_reg
);
  localparam logic [3:0] A_FEAT = 4'd1, A_CNT = 4'd2, A_CYL_L = 4'd4,
                         A_CYL_H = 4'd5, A_DEV = 4'd6, A_CMD = 4'd7, A_AUX = 4'd8;
  localparam logic [2:0] ST_LAST = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_AUX_ON, S_SEL, S_SETTLE, S_ISSUE, S_HOLD, S_POLL, S_AUX_OFF, S_FIN
  } st_t;

  st_t         st;
  logic [31:0] cnt;
  logic [2:0]  step, nxt, idx;
  logic [6:1]  take;
  logic [3:0]  wl_addr;
  logic [7:0]  wl_data;
  logic        wl_last;

  wire [7:0] dev      = 8'hA0 | {3'b000, drive_sel, 4'h0};
  wire [3:0] head_m1  = 4'(geo_heads - 5'd1);
  wire       modes_ok = can_set_modes & modes_known;
  wire [7:0] xfer_byte = udma_en ? (8'h40 | {5'd0, udma_mode}) : (8'h20 | {5'd0, dma_mode});
  wire       dev_rdy  = !stat_in[7] && stat_in[6];

  assign take = {1'b1, multi_cnt != 8'd1, !lba_mode,
                 modes_ok & (udma_en | dma_en), modes_ok, 1'b1};

  always_comb begin
    nxt = ST_LAST;
    for (int k = 5; k >= 1; k--)
      if (3'(k) > step && take[k]) nxt = 3'(k);
  end

  always_comb begin
    wl_addr = A_CMD;
    wl_data = 8'h00;
    wl_last = 1'b0;
    case (step)
      3'd1: case (idx)
        3'd0: begin wl_addr = A_DEV; wl_data = dev; end
        default: begin wl_data = 8'h10; wl_last = 1'b1; end
      endcase
      3'd2, 3'd3: case (idx)
        3'd0: begin wl_addr = A_FEAT; wl_data = 8'h03; end
        3'd1: begin
          wl_addr = A_CNT;
          wl_data = (step == 3'd2) ? (8'h08 | {5'd0, pio_mode}) : xfer_byte;
        end
        3'd2: begin wl_addr = A_DEV; wl_data = dev; end
        default: begin wl_data = 8'hEF; wl_last = 1'b1; end
      endcase
      3'd4: case (idx)
        3'd0: begin wl_addr = A_CNT; wl_data = geo_spt; end
        3'd1: begin wl_addr = A_CYL_L; wl_data = geo_cyl[7:0]; end
        3'd2: begin wl_addr = A_CYL_H; wl_data = geo_cyl[15:8]; end
        3'd3: begin wl_addr = A_DEV; wl_data = dev | {4'h0, head_m1}; end
        default: begin wl_data = 8'h91; wl_last = 1'b1; end
      endcase
      default: case (idx)
        3'd0: begin wl_addr = A_CNT; wl_data = multi_cnt; end
        3'd1: begin wl_addr = A_DEV; wl_data = dev; end
        default: begin wl_data = 8'hC6; wl_last = 1'b1; end
      endcase
    endcase
  end

  always_comb begin
    wr_en = 1'b0;
    wr_addr = 4'd0;
    wr_data = 8'h00;
    case (st)
      S_AUX_ON:  if (!no_aux_ctl) begin wr_en = 1'b1; wr_addr = A_AUX; wr_data = 8'h0A; end
      S_SEL:     begin wr_en = 1'b1; wr_addr = A_DEV; wr_data = dev; end
      S_ISSUE:   begin wr_en = 1'b1; wr_addr = wl_addr; wr_data = wl_data; end
      S_AUX_OFF: if (!no_aux_ctl) begin wr_en = 1'b1; wr_addr = A_AUX; wr_data = 8'h08; end
      default: ;
    endcase
  end

  assign done = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      step <= '0;
      idx <= '0;
      ready <= 1'b0;
      err_code <= 2'd0;
      err_step <= 3'd0;
      err_reg <= 8'h00;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          if (ready) st <= S_FIN;
          else begin
            err_code <= 2'd0;
            err_step <= 3'd0;
            err_reg <= 8'h00;
            step <= 3'd0;
            st <= S_AUX_ON;
          end
        end
        S_AUX_ON: st <= S_SEL;
        S_SEL: begin cnt <= '0; st <= S_SETTLE; end
        S_SETTLE, S_HOLD:
          if (cnt == SETTLE_CYC - 32'd1 && st == S_SETTLE || cnt == HOLD_CYC - 32'd1 && st == S_HOLD) begin
            cnt <= '0;
            st <= S_POLL;
          end else cnt <= cnt + 32'd1;
        S_ISSUE:
          if (wl_last) begin cnt <= '0; st <= S_HOLD; end
          else idx <= idx + 3'd1;
        S_POLL:
          if (dev_rdy) begin
            cnt <= '0;
            if (step != 3'd0 && stat_in[5]) begin
              err_code <= 2'd3; err_step <= step; st <= S_AUX_OFF;
            end else if (step != 3'd0 && stat_in[0]) begin
              err_code <= 2'd2; err_step <= step; err_reg <= err_in; st <= S_AUX_OFF;
            end else if (nxt == ST_LAST) st <= S_AUX_OFF;
            else begin step <= nxt; idx <= 3'd0; st <= S_ISSUE; end
          end else if (cnt == TIMEOUT_CYC - 32'd1) begin
            err_code <= 2'd1; err_step <= step; st <= S_AUX_OFF;
          end else cnt <= cnt + 32'd1;
        S_AUX_OFF: begin ready <= (err_code == 2'd0); st <= S_FIN; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_bringup_seq_chk.sv
module ata_bringup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       no_aux_ctl,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic       done,
  input logic       ready,
  input logic [1:0] err_code
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ready) |-> done);
  // R2
  aux_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && no_aux_ctl) |-> wr_addr != 4'd8);
  // R9
  ready_clean_chk: assert property (@(posedge clk) disable iff (!rst_n) ready |-> err_code == 2'd0);
  // R8
  fail_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code != 2'd0) |-> !ready);
  // R10
  quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !wr_en);
endmodule

bind ata_bringup_seq ata_bringup_seq_chk chk_i (.*);

// File: tb/ata_bringup_seq_tb.sv
module ata_bringup_seq_tb_top;
  localparam int SET = 6, HLD = 4, TMO = 40;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic drv, no_aux, cms, mk, ue, de, lba;
  logic [2:0] pio, dma, udma;
  logic [15:0] cyl;
  logic [4:0] heads;
  logic [7:0] spt, multi, f_err;
  int f_idx = 0, f_kind = 0;
  logic mdl_clr = 1'b0;
  logic [7:0] stat, errv;
  logic wr_en, done, ready;
  logic [3:0] wr_addr;
  logic [7:0] wr_data, err_reg;
  logic [1:0] err_code;
  logic [2:0] err_step;

  always #2 clk = ~clk;

  ata_bringup_seq #(.SETTLE_CYC(SET), .HOLD_CYC(HLD), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .drive_sel(drv), .no_aux_ctl(no_aux),
    .can_set_modes(cms), .modes_known(mk), .udma_en(ue), .dma_en(de), .lba_mode(lba),
    .pio_mode(pio), .dma_mode(dma), .udma_mode(udma), .geo_cyl(cyl), .geo_heads(heads),
    .geo_spt(spt), .multi_cnt(multi), .stat_in(stat), .err_in(errv),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .ready(ready),
    .err_code(err_code), .err_step(err_step), .err_reg(err_reg));

  int cyc = 0, cmd_n = 0, busy = 0, n_log = 0, n_done = 0;
  logic [3:0] la[64];
  logic [7:0] ld[64];
  int lt[64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || mdl_clr) begin
      cmd_n <= 0; busy <= 0; n_log <= 0; n_done <= 0;
    end else begin
      if (done) n_done <= n_done + 1;
      if (wr_en && wr_addr == 4'd7) begin cmd_n <= cmd_n + 1; busy <= 3; end
      else if (busy > 0) busy <= busy - 1;
      if (wr_en && n_log < 64) begin
        la[n_log] <= wr_addr; ld[n_log] <= wr_data; lt[n_log] <= cyc; n_log <= n_log + 1;
      end
    end
  end

  assign stat = (busy > 0) ? 8'h80 :
                (cmd_n == f_idx && f_kind == 1) ? 8'h00 :
                (cmd_n == f_idx && f_kind == 2) ? 8'h41 :
                (cmd_n == f_idx && f_kind == 3) ? 8'h61 : 8'h40;
  assign errv = f_err;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [3:0] ea[64];
  logic [7:0] ed[64];
  int e_n, e_code, e_step, e_reg, e_ready;
  int steps[5];
  int n_steps;

  function automatic bit taken(input int s);
    case (s)
      2: return cms && mk;
      3: return cms && mk && (ue || de);
      4: return !lba;
      5: return multi != 8'd1;
      default: return 1'b1;
    endcase
  endfunction

  task automatic list_steps();
    n_steps = 0;
    for (int s = 1; s <= 5; s++) if (taken(s)) begin steps[n_steps] = s; n_steps++; end
  endtask

  task automatic push(input logic [3:0] a, input logic [7:0] d);
    ea[e_n] = a; ed[e_n] = d; e_n++;
  endtask

  task automatic build_exp();
    logic [7:0] dv;
    dv = 8'hA0 | (8'(drv) << 4);
    list_steps();
    e_n = 0; e_code = 0; e_step = 0; e_reg = 0;
    if (!no_aux) push(4'd8, 8'h0A);
    push(4'd6, dv);
    if (f_kind == 1 && f_idx == 0) e_code = 1;
    else
      for (int j = 0; j < n_steps; j++) begin
        case (steps[j])
          1: begin push(6, dv); push(7, 8'h10); end
          2: begin push(1, 8'h03); push(2, 8'h08 | 8'(pio)); push(6, dv); push(7, 8'hEF); end
          3: begin
            push(1, 8'h03); push(2, ue ? (8'h40 | 8'(udma)) : (8'h20 | 8'(dma)));
            push(6, dv); push(7, 8'hEF);
          end
          4: begin
            push(2, spt); push(4, cyl[7:0]); push(5, cyl[15:8]);
            push(6, dv | 8'(4'(heads - 5'd1))); push(7, 8'h91);
          end
          default: begin push(2, multi); push(6, dv); push(7, 8'hC6); end
        endcase
        if (f_kind != 0 && f_idx == j + 1) begin
          e_code = f_kind; e_step = steps[j]; e_reg = (f_kind == 2) ? int'(f_err) : 0;
          break;
        end
      end
    if (!no_aux) push(4'd8, 8'h08);
    e_ready = (e_code == 0);
  endtask

  task automatic run_start();
    int w;
    @(negedge clk) mdl_clr = 1'b1;
    @(negedge clk) mdl_clr = 1'b0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    w = 0;
    while (n_done == 0 && w < 2000) begin @(negedge clk); w++; end
    repeat (5) @(negedge clk);
  endtask

  task automatic check_run(input string tag, input bit noop);
    int bad;
    if (noop) e_n = 0;
    chk({tag, " R10 done count"}, n_done, 1);
    chk({tag, " R4 write count"}, n_log, e_n);
    bad = -1;
    for (int i = 0; i < e_n && i < n_log; i++)
      if (bad < 0 && (la[i] != ea[i] || ld[i] != ed[i])) bad = i;
    if (bad >= 0) chk({tag, " R5 R6 write stream"}, {la[bad], ld[bad]}, {ea[bad], ed[bad]});
    else chk({tag, " R5 R6 write stream"}, 0, 0);
    chk({tag, " R7 R8 err_code"}, err_code, noop ? 0 : e_code);
    chk({tag, " R7 err_step"}, err_step, noop ? 0 : e_step);
    chk({tag, " R8 err_reg"}, err_reg, noop ? 0 : e_reg);
    chk({tag, " R9 ready"}, ready, noop ? 1 : e_ready);
  endtask

  task automatic set_all(input bit a, b, c, d, e, f, g, h, input logic [7:0] m);
    drv = a; no_aux = b; cms = c; mk = d; ue = e; de = f; lba = g; f_kind = h ? f_kind : 0; multi = m;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int r;
    r = $urandom(32'd2024);
    pio = 3'd4; dma = 3'd2; udma = 3'd5; cyl = 16'h1234; heads = 5'd16; spt = 8'd63; f_err = 8'h04;
    set_all(0, 0, 1, 1, 1, 1, 0, 0, 8'd16);
    do_reset();
    @(negedge clk);
    chk("R1 done", done, 0); chk("R1 ready", ready, 0); chk("R1 wr_en", wr_en, 0);
    chk("R1 err_code", err_code, 0); chk("R1 err_step", err_step, 0); chk("R1 err_reg", err_reg, 0);

    f_kind = 0; f_idx = 0; build_exp(); run_start(); check_run("all-steps udma", 0);
    chk("R3 select gap", lt[2] - lt[1], SET + 2);
    for (int i = 0; i + 1 < n_log; i++)
      if (la[i] == 4'd7) chk("R7 hold gap", lt[i + 1] - lt[i], HLD + 2);
    chk("R2 first aux", {la[0], ld[0]}, {4'd8, 8'h0A});

    build_exp(); run_start(); check_run("R10 start while ready", 1);

    do_reset(); set_all(1, 0, 1, 1, 0, 1, 1, 0, 8'd8);
    build_exp(); run_start(); check_run("R6 mdma lba", 0);

    do_reset(); set_all(0, 1, 0, 1, 1, 1, 1, 0, 8'd1);
    build_exp(); run_start(); check_run("R2 R4 recal only no aux", 0);

    do_reset(); set_all(1, 0, 1, 1, 0, 0, 0, 0, 8'd4);
    build_exp(); run_start(); check_run("R4 no dma step", 0);

    do_reset(); set_all(0, 0, 1, 1, 1, 0, 0, 0, 8'd8);
    f_idx = 0; f_kind = 1; build_exp(); run_start(); check_run("R7 initial timeout", 0);

    do_reset(); f_idx = 1; f_kind = 2; f_err = 8'h10; build_exp(); run_start(); check_run("R8 recal error", 0);
    f_kind = 0; build_exp(); run_start(); check_run("R9 rerun after failure", 0);

    do_reset(); list_steps(); f_idx = n_steps; f_kind = 3; build_exp(); run_start();
    check_run("R8 fault priority last step", 0);

    do_reset(); f_idx = 2; f_kind = 1; build_exp(); run_start(); check_run("R7 pio timeout", 0);

    for (int it = 0; it < 40; it++) begin
      do_reset();
      drv = 1'($urandom); no_aux = 1'($urandom); cms = 1'($urandom); mk = 1'($urandom);
      ue = 1'($urandom); de = 1'($urandom); lba = 1'($urandom);
      multi = ($urandom % 3 == 0) ? 8'd1 : 8'($urandom);
      pio = 3'($urandom); dma = 3'($urandom); udma = 3'($urandom);
      cyl = 16'($urandom); heads = 5'(1 + $urandom % 16); spt = 8'($urandom); f_err = 8'($urandom);
      list_steps();
      f_idx = $urandom % (n_steps + 2);
      if (f_idx > n_steps) f_kind = 0;
      else if (f_idx == 0) f_kind = 1;
      else f_kind = 1 + $urandom % 3;
      build_exp(); run_start(); check_run("R4 R5 R6 R8 random", 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule